// File: doc/BRIEF.md
# Garbage Collection Copy Engine

This engine relocates live data units from one superblock to another in response to a single command, so the host never has to read the data out and write it back. The command names a source superblock, a destination superblock, the destination's current write pointer and a selection rule. The rule is either a valid-unit bitmap with one bit per source unit, or an inclusive logical-address window that is tested against the logical address stored in each unit's metadata.

The engine walks the source units in ascending index order. For every selected unit it issues one move request to the media side, which carries the source and destination physical addresses. It then queues an address-update event that pairs the old and the new physical address, so a mapping table can be updated by compare-and-swap. A physical address is the superblock number concatenated above the unit index. When the destination runs out of space before the walk ends, the engine stops and reports a partial result together with the source index at which to resume.

The controller is one state machine with six named states. IDLE waits for `cmd_valid`. SCAN looks at the current index: at the end of the walk it goes to FINISH; in filter mode it goes to LOOKUP; in bitmap mode a selected unit goes to MOVE, or to FINISH when the destination is full, and an unselected unit stays in SCAN with the index advanced. LOOKUP holds `md_req` until `md_rsp_valid`, then goes to MOVE, FINISH or SCAN by the same rule. MOVE holds `mv_req` until `mv_ack`, then goes to EMIT. EMIT waits until the event queue has room, pushes the event and returns to SCAN. FINISH raises `done` for one cycle and returns to IDLE.

Top module: `gc_copy_engine`

## Requirements
- R1: After reset, `busy`, `done`, `md_req`, `mv_req` and `ev_valid` are all low.
- R2: With `cmd_filter`=0, exactly the source units whose bit `cmd_bitmap[i]` is 1 are moved, in ascending order of index i.
- R3: With `cmd_filter`=1, unit i is moved exactly when its stored logical address L satisfies `cmd_lba_lo` <= L <= `cmd_lba_hi`, with both bounds inclusive. The bitmap is ignored in this mode.
- R4: Move k of a command (counting from 0) has `mv_src` = {src, i} and `mv_dst` = {dst, wp+k}, where wp is `cmd_dst_wp`. The request and its addresses stay stable until `mv_ack`.
- R5: Every acknowledged move produces exactly one event, with `ev_old` equal to the move's source address and `ev_new` equal to its destination address. Events come out in move order.
- R6: When the walk ends, `done` is high for exactly one cycle. At that cycle `done_count` is the number of units moved, `done_partial`=0 and `done_next`=UNITS.
- R7: If a selected unit is reached while the destination write pointer equals UNITS, nothing more is moved. `done` then carries `done_partial`=1 and `done_next` = that unit's index.
- R8: While the event queue is full, the walk stalls. No further move is requested beyond the one awaiting its queue slot, and no event is lost.
- R9: A `cmd_valid` received while `busy` is high is ignored: it changes neither the running command nor produces a second `done`.
- R10: In bitmap mode no metadata lookup (`md_req`) is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Start a command (taken only when idle) |
| cmd_src_sb | input | SB_W | Source superblock |
| cmd_dst_sb | input | SB_W | Destination superblock |
| cmd_dst_wp | input | IDX_W+1 | First free destination unit (UNITS means full) |
| cmd_filter | input | 1 | 0 = bitmap selection, 1 = address window |
| cmd_bitmap | input | UNITS | Valid-unit bitmap, bit i for source unit i |
| cmd_lba_lo | input | LBA_W | Window lower bound (inclusive) |
| cmd_lba_hi | input | LBA_W | Window upper bound (inclusive) |
| busy | output | 1 | Command in progress |
| md_req | output | 1 | Metadata lookup request |
| md_addr | output | PA_W | Unit being looked up |
| md_rsp_valid | input | 1 | Lookup result valid |
| md_lba | input | LBA_W | Stored logical address of the unit |
| mv_req | output | 1 | Move request toward media |
| mv_src | output | PA_W | Source physical address |
| mv_dst | output | PA_W | Destination physical address |
| mv_ack | input | 1 | Move accepted |
| ev_valid | output | 1 | Address-update event available |
| ev_ready | input | 1 | Event consumer ready |
| ev_old | output | PA_W | Previous physical address |
| ev_new | output | PA_W | New physical address |
| done | output | 1 | One-cycle completion pulse |
| done_count | output | IDX_W+1 | Units moved |
| done_partial | output | 1 | Stopped on a full destination |
| done_next | output | IDX_W+1 | Source index to resume at |

## Verification
Random bitmaps with random write pointers separate correct selection and address sequencing from off-by-one errors in the index or the pointer, and some of them run into a full destination. Random address windows over random metadata test the filter, and a directed window whose edges equal stored addresses tells an inclusive comparison from an exclusive one. A consumer that refuses events for a long time shows whether the walk stalls or drops events. A second command issued mid-run and an all-zero bitmap cover the ignored-command case and the empty walk, and a write pointer already at the end covers the immediate partial stop.

// File: rtl/gce_pkg.sv
package gce_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_SCAN,
        S_LOOKUP,
        S_MOVE,
        S_EMIT,
        S_FINISH
    } gce_state_t;
endpackage

// File: rtl/gce_select.sv
module gce_select #(
    parameter int LBA_W = 16
) (
    input  logic             use_filter,
    input  logic             map_bit,
    input  logic [LBA_W-1:0] lba,
    input  logic [LBA_W-1:0] lo,
    input  logic [LBA_W-1:0] hi,
    output logic             hit
);
    always_comb begin
        if (use_filter) hit = (lba >= lo) && (lba <= hi);
        else            hit = map_bit;
    end
endmodule

// File: rtl/gce_evq.sv
module gce_evq #(
    parameter int W     = 16,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    input  logic         pop,
    output logic         valid,
    output logic [W-1:0] dout
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_p, rd_p;
    logic [CW-1:0] fill;

    assign full  = (fill == CW'(DEPTH));
    assign valid = (fill != '0);
    assign dout  = mem[rd_p];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_p <= '0;
            rd_p <= '0;
            fill <= '0;
        end else begin
            if (push && !full) begin
                mem[wr_p] <= din;
                wr_p <= (wr_p == PW'(DEPTH - 1)) ? '0 : wr_p + 1'b1;
            end
            if (pop && valid)
                rd_p <= (rd_p == PW'(DEPTH - 1)) ? '0 : rd_p + 1'b1;
            case ({push && !full, pop && valid})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/gc_copy_engine.sv
module gc_copy_engine
    import gce_pkg::*;
#(
    parameter int UNITS     = 16,
    parameter int SB_W      = 4,
    parameter int LBA_W     = 16,
    parameter int EVQ_DEPTH = 4,
    localparam int IDX_W    = $clog2(UNITS),
    localparam int PA_W     = SB_W + IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [SB_W-1:0]  cmd_src_sb,
    input  logic [SB_W-1:0]  cmd_dst_sb,
    input  logic [IDX_W:0]   cmd_dst_wp,
    input  logic             cmd_filter,
    input  logic [UNITS-1:0] cmd_bitmap,
    input  logic [LBA_W-1:0] cmd_lba_lo,
    input  logic [LBA_W-1:0] cmd_lba_hi,
    output logic             busy,
    output logic             md_req,
    output logic [PA_W-1:0]  md_addr,
    input  logic             md_rsp_valid,
    input  logic [LBA_W-1:0] md_lba,
    output logic             mv_req,
    output logic [PA_W-1:0]  mv_src,
    output logic [PA_W-1:0]  mv_dst,
    input  logic             mv_ack,
    output logic             ev_valid,
    input  logic             ev_ready,
    output logic [PA_W-1:0]  ev_old,
    output logic [PA_W-1:0]  ev_new,
    output logic             done,
    output logic [IDX_W:0]   done_count,
    output logic             done_partial,
    output logic [IDX_W:0]   done_next
);
    localparam logic [IDX_W:0] LIMIT = (IDX_W + 1)'(UNITS);

    gce_state_t       state, state_nx;
    logic [IDX_W:0]   idx, wp, cnt;
    logic [SB_W-1:0]  src_q, dst_q;
    logic             filter_q, partial_q;
    logic [UNITS-1:0] bitmap_q;
    logic [LBA_W-1:0] lo_q, hi_q;

    logic walk_end, dst_full, hit, take, skip, stop_full, q_full, push;
    logic [2*PA_W-1:0] ev_word;

    assign walk_end = (idx == LIMIT);
    assign dst_full = (wp == LIMIT);

    gce_select #(.LBA_W(LBA_W)) u_sel (
        .use_filter (filter_q),
        .map_bit    (bitmap_q[idx[IDX_W-1:0]]),
        .lba        (md_lba),
        .lo         (lo_q),
        .hi         (hi_q),
        .hit        (hit)
    );

    always_comb begin
        take = 1'b0;
        skip = 1'b0;
        if (state == S_SCAN && !walk_end && !filter_q) begin
            take = hit;
            skip = !hit;
        end else if (state == S_LOOKUP && md_rsp_valid) begin
            take = hit;
            skip = !hit;
        end
        stop_full = take && dst_full;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next-state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (cmd_valid) state_nx = S_SCAN;
            S_SCAN: begin
                if (walk_end)       state_nx = S_FINISH;
                else if (filter_q)  state_nx = S_LOOKUP;
                else if (stop_full) state_nx = S_FINISH;
                else if (take)      state_nx = S_MOVE;
            end
            S_LOOKUP: begin
                if (stop_full)  state_nx = S_FINISH;
                else if (take)  state_nx = S_MOVE;
                else if (skip)  state_nx = S_SCAN;
            end
            S_MOVE:   if (mv_ack)  state_nx = S_EMIT;
            S_EMIT:   if (!q_full) state_nx = S_SCAN;
            S_FINISH: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy   = (state != S_IDLE);
        md_req = (state == S_LOOKUP);
        mv_req = (state == S_MOVE);
        done   = (state == S_FINISH);
        push   = (state == S_EMIT) && !q_full;
    end

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0; wp <= '0; cnt <= '0; partial_q <= 1'b0;
            src_q <= '0; dst_q <= '0; filter_q <= 1'b0;
            bitmap_q <= '0; lo_q <= '0; hi_q <= '0;
        end else if (state == S_IDLE) begin
            if (cmd_valid) begin
                idx <= '0; cnt <= '0; partial_q <= 1'b0;
                wp <= cmd_dst_wp;
                src_q <= cmd_src_sb; dst_q <= cmd_dst_sb;
                filter_q <= cmd_filter; bitmap_q <= cmd_bitmap;
                lo_q <= cmd_lba_lo; hi_q <= cmd_lba_hi;
            end
        end else begin
            if (skip)      idx <= idx + 1'b1;
            if (stop_full) partial_q <= 1'b1;
            if (push) begin
                idx <= idx + 1'b1;
                wp  <= wp + 1'b1;
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign md_addr      = {src_q, idx[IDX_W-1:0]};
    assign mv_src       = {src_q, idx[IDX_W-1:0]};
    assign mv_dst       = {dst_q, wp[IDX_W-1:0]};
    assign ev_word      = {mv_src, mv_dst};
    assign done_count   = cnt;
    assign done_partial = partial_q;
    assign done_next    = idx;

    logic [2*PA_W-1:0] ev_out;

    gce_evq #(.W(2*PA_W), .DEPTH(EVQ_DEPTH)) u_evq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (ev_word),
        .full  (q_full),
        .pop   (ev_ready),
        .valid (ev_valid),
        .dout  (ev_out)
    );

    assign ev_old = ev_out[2*PA_W-1:PA_W];
    assign ev_new = ev_out[PA_W-1:0];
endmodule

// File: rtl/gce_checker.sv
module gce_checker #(
    parameter int UNITS = 16,
    parameter int SB_W  = 4,
    localparam int IDX_W = $clog2(UNITS),
    localparam int PA_W  = SB_W + IDX_W
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            md_req,
    input logic            mv_req,
    input logic            mv_ack,
    input logic [PA_W-1:0] mv_src,
    input logic [PA_W-1:0] mv_dst,
    input logic            ev_valid,
    input logic            ev_ready,
    input logic [PA_W-1:0] ev_old,
    input logic [PA_W-1:0] ev_new,
    input logic            done,
    input logic            done_partial,
    input logic [IDX_W:0]  done_next,
    input logic [IDX_W:0]  done_count
);
    p_mv_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mv_req && !mv_ack |=> mv_req && $stable(mv_src) && $stable(mv_dst));

    p_ev_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && !ev_ready |=> ev_valid && $stable(ev_old) && $stable(ev_new));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    p_complete_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done && !done_partial |-> done_next == (IDX_W + 1)'(UNITS));

    p_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> done_count <= (IDX_W + 1)'(UNITS));

    p_partial_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done && done_partial |-> done_next < (IDX_W + 1)'(UNITS));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !md_req && !mv_req && !done);

    p_one_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        md_req |-> !mv_req);
endmodule

bind gc_copy_engine gce_checker #(.UNITS(UNITS), .SB_W(SB_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .md_req       (md_req),
    .mv_req       (mv_req),
    .mv_ack       (mv_ack),
    .mv_src       (mv_src),
    .mv_dst       (mv_dst),
    .ev_valid     (ev_valid),
    .ev_ready     (ev_ready),
    .ev_old       (ev_old),
    .ev_new       (ev_new),
    .done         (done),
    .done_partial (done_partial),
    .done_next    (done_next),
    .done_count   (done_count)
);

// File: tb/test_gc_copy_engine.sv
module test_gc_copy_engine;
    localparam int UNITS = 16;
    localparam int SB_W  = 4;
    localparam int LBA_W = 16;
    localparam int DEPTH = 4;
    localparam int IDX_W = 4;
    localparam int PA_W  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic             cmd_valid = 1'b0;
    logic [SB_W-1:0]  cmd_src_sb = '0, cmd_dst_sb = '0;
    logic [IDX_W:0]   cmd_dst_wp = '0;
    logic             cmd_filter = 1'b0;
    logic [UNITS-1:0] cmd_bitmap = '0;
    logic [LBA_W-1:0] cmd_lba_lo = '0, cmd_lba_hi = '0;
    logic             busy, md_req, mv_req, ev_valid, done, done_partial;
    logic [PA_W-1:0]  md_addr, mv_src, mv_dst, ev_old, ev_new;
    logic             md_rsp_valid = 1'b0, mv_ack = 1'b0, ev_ready = 1'b0;
    logic [LBA_W-1:0] md_lba = '0;
    logic [IDX_W:0]   done_count, done_next;

    gc_copy_engine #(.UNITS(UNITS), .SB_W(SB_W), .LBA_W(LBA_W), .EVQ_DEPTH(DEPTH)) i_gc_copy_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_src_sb(cmd_src_sb),
        .cmd_dst_sb(cmd_dst_sb), .cmd_dst_wp(cmd_dst_wp), .cmd_filter(cmd_filter),
        .cmd_bitmap(cmd_bitmap), .cmd_lba_lo(cmd_lba_lo), .cmd_lba_hi(cmd_lba_hi),
        .busy(busy), .md_req(md_req), .md_addr(md_addr), .md_rsp_valid(md_rsp_valid),
        .md_lba(md_lba), .mv_req(mv_req), .mv_src(mv_src), .mv_dst(mv_dst),
        .mv_ack(mv_ack), .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_old(ev_old),
        .ev_new(ev_new), .done(done), .done_count(done_count),
        .done_partial(done_partial), .done_next(done_next)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0;
    logic [LBA_W-1:0] lba_tab [UNITS];
    logic [PA_W-1:0]  got_src [32], got_dst [32], got_old [32], got_new [32];
    int n_mv = 0, n_ev = 0, n_md = 0, n_done = 0;
    bit ev_hold = 1'b0;
    int exp_idx [UNITS];
    int n_exp, exp_next;
    bit exp_part;

    task automatic check_eq(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // metadata responder
    always @(negedge clk) begin
        if (md_req && !md_rsp_valid) begin
            md_rsp_valid = 1'b1;
            md_lba = lba_tab[md_addr[IDX_W-1:0]];
            n_md++;
        end else md_rsp_valid = 1'b0;
    end

    // media responder
    always @(negedge clk) begin
        if (mv_req && !mv_ack && ($urandom % 2 == 0)) begin
            mv_ack = 1'b1;
            if (n_mv < 32) begin got_src[n_mv] = mv_src; got_dst[n_mv] = mv_dst; end
            n_mv++;
        end else mv_ack = 1'b0;
    end

    // event consumer and done monitor
    always @(negedge clk) begin
        bit rdy;
        rdy = !ev_hold && ($urandom % 4 != 0);
        if (ev_valid && rdy) begin
            if (n_ev < 32) begin got_old[n_ev] = ev_old; got_new[n_ev] = ev_new; end
            n_ev++;
        end
        ev_ready = rdy;
        if (done) n_done++;
    end

    // watchdog
    always @(negedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic expect_run(input bit f, input logic [UNITS-1:0] bm,
                              input int lo, input int hi, input int wp);
        n_exp = 0; exp_part = 0; exp_next = UNITS;
        for (int i = 0; i < UNITS; i++) begin
            bit sel;
            sel = f ? (int'(lba_tab[i]) >= lo && int'(lba_tab[i]) <= hi) : bm[i];
            if (sel) begin
                if (wp + n_exp == UNITS) begin
                    exp_part = 1; exp_next = i;
                    break;
                end
                exp_idx[n_exp] = i;
                n_exp++;
            end
        end
    endtask

    task automatic start_cmd(input bit f, input logic [UNITS-1:0] bm, input int lo,
                             input int hi, input int wp, input int s, input int d);
        @(negedge clk);
        cmd_filter = f; cmd_bitmap = bm; cmd_lba_lo = LBA_W'(lo); cmd_lba_hi = LBA_W'(hi);
        cmd_dst_wp = (IDX_W + 1)'(wp); cmd_src_sb = SB_W'(s); cmd_dst_sb = SB_W'(d);
        cmd_valid = 1'b1;
        n_mv = 0; n_ev = 0; n_md = 0; n_done = 0;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic finish_cmd(input bit f, input int wp, input int s, input int d,
                              input string rq);
        int dc, dp, dn;
        while (!done) @(negedge clk);
        dc = int'(done_count); dp = int'(done_partial); dn = int'(done_next);
        for (int t = 0; t < 300 && n_ev < n_mv; t++) @(negedge clk);
        check_eq({rq, " R6 done_count"}, dc, n_exp);
        check_eq({rq, " R7 done_partial"}, dp, int'(exp_part));
        check_eq({rq, " R7 done_next"}, dn, exp_next);
        check_eq({rq, " move count"}, n_mv, n_exp);
        check_eq({rq, " R5 event count"}, n_ev, n_exp);
        for (int k = 0; k < n_exp && k < n_mv; k++) begin
            int es, ed;
            es = s * UNITS + exp_idx[k];
            ed = d * UNITS + ((wp + k) % UNITS);
            check_eq({rq, " move src"}, int'(got_src[k]), es);
            check_eq({rq, " R4 move dst"}, int'(got_dst[k]), ed);
            if (k < n_ev) begin
                check_eq({rq, " R5 event old"}, int'(got_old[k]), es);
                check_eq({rq, " R5 event new"}, int'(got_new[k]), ed);
            end
        end
        if (!f) check_eq("R10 no lookups in bitmap mode", n_md, 0);
    endtask

    task automatic run(input bit f, input logic [UNITS-1:0] bm, input int lo, input int hi,
                       input int wp, input int s, input int d, input string rq);
        expect_run(f, bm, lo, hi, wp);
        start_cmd(f, bm, lo, hi, wp, s, d);
        finish_cmd(f, wp, s, d, rq);
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < UNITS; i++) lba_tab[i] = LBA_W'($urandom_range(0, 99));
        repeat (4) @(negedge clk);
        check_eq("R1 busy after reset", int'(busy), 0);
        check_eq("R1 done after reset", int'(done), 0);
        check_eq("R1 md_req after reset", int'(md_req), 0);
        check_eq("R1 mv_req after reset", int'(mv_req), 0);
        check_eq("R1 ev_valid after reset", int'(ev_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // random bitmap commands
        for (int r = 0; r < 6; r++)
            run(1'b0, UNITS'($urandom), 0, 0, $urandom_range(0, UNITS),
                $urandom_range(0, 15), $urandom_range(0, 15), "R2 bitmap");

        // random window commands
        for (int r = 0; r < 6; r++) begin
            int lo, hi;
            for (int i = 0; i < UNITS; i++) lba_tab[i] = LBA_W'($urandom_range(0, 99));
            lo = $urandom_range(0, 50);
            hi = lo + $urandom_range(0, 49);
            run(1'b1, UNITS'($urandom), lo, hi, $urandom_range(0, 8),
                $urandom_range(0, 15), $urandom_range(0, 15), "R3 window");
        end

        // window edges are inclusive
        for (int i = 0; i < UNITS; i++) lba_tab[i] = LBA_W'(200);
        lba_tab[2] = 29; lba_tab[3] = 30; lba_tab[7] = 60; lba_tab[9] = 61; lba_tab[11] = 45;
        run(1'b1, '0, 30, 60, 0, 3, 5, "R3 inclusive edges");

        // destination already full: immediate partial stop
        run(1'b0, 16'h0130, 0, 0, UNITS, 1, 2, "R7 full at start");
        // destination fills mid-walk
        run(1'b0, 16'hFFFF, 0, 0, 13, 4, 6, "R7 fills mid-walk");
        // empty bitmap
        run(1'b0, '0, 0, 0, 0, 2, 2, "R2 empty bitmap");
        // last unit only
        run(1'b0, 16'h8000, 0, 0, 15, 7, 8, "R2 last unit");

        // stalled event consumer
        ev_hold = 1'b1;
        expect_run(1'b0, 16'hFFFF, 0, 0, 0);
        start_cmd(1'b0, 16'hFFFF, 0, 0, 0, 9, 10);
        repeat (150) @(negedge clk);
        check_eq("R8 moves while queue full", n_mv, DEPTH + 1);
        check_eq("R8 still busy while stalled", int'(busy), 1);
        ev_hold = 1'b0;
        finish_cmd(1'b0, 0, 9, 10, "R8 after release");

        // command issued while busy
        for (int i = 0; i < UNITS; i++) lba_tab[i] = LBA_W'(i * 5);
        expect_run(1'b1, '0, 10, 50, 0);
        start_cmd(1'b1, '0, 10, 50, 0, 12, 13);
        repeat (3) @(negedge clk);
        cmd_filter = 1'b0; cmd_bitmap = 16'h0003; cmd_dst_wp = '0;
        cmd_src_sb = 4'd1; cmd_dst_sb = 4'd1; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        finish_cmd(1'b1, 0, 12, 13, "R9 busy command");
        repeat (40) @(negedge clk);
        check_eq("R9 single done pulse", n_done, 1);
        check_eq("R9 no extra moves", n_mv, n_exp);
        check_eq("R9 idle after run", int'(busy), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule